// File: doc/BRIEF.md
# Programmable Lookup Cell Chain with Carry and Share Ripple

This block is a tile of combinational logic cells. Each cell is configured to work in one of two ways. As a lookup table it reads between zero and six of its pins and returns one bit of its configuration mask. As an arithmetic element it uses a 32-bit mask to form a propagate term and a generate term, drives a sum on its combinational output, and passes a carry and a share bit to the next cell.

The cells are chained in a fixed order. Cell 0 takes carry and share from the tile inputs. A tile input is fed either by the carry-out and share-out of the previous tile or by a chain-start constant. Each later cell takes them from the cell before it, and the tile's carry and share outputs come from the last cell. The whole tile is combinational and has no clock.

Top module: `lutc_tile`

## Requirements
- R1: In lookup mode with n used inputs (n = 0..6), a cell outputs bit `idx` of its 64-bit mask field `cfgMask[c*64 +: 64]`. `idx` is built from pin A as bit 0, B as bit 1, C as bit 2, D as bit 3, E as bit 4 and F as bit 5.
- R2: In lookup mode, pins at positions n and above are treated as 0. A count field value of 7 behaves as 6.
- R3: A zero-input cell outputs mask bit 0 constantly. A one-input cell with mask bits [1:0] = 2'b01 outputs the inverse of pin A.
- R4: In arithmetic mode (`cfgArith[c]`=1) the propagate term is P = mask[{D,C,B,A}] from bits [15:0]. The generate term is G = mask[16 + {E,C,B,A}] from bits [31:16], so E serves as the second D input. The combinational output is P XOR carry-in XOR share-in.
- R5: In arithmetic mode, carry-out = G OR (P AND carry-in), and share-out = G.
- R6: In lookup mode, carry-out equals carry-in, share-out equals share-in, and the combinational output does not depend on either of them.
- R7: Cell k takes carry and share from cell k-1. Cell 0 takes them from `chainCarryIn`/`chainShareIn`. `tileCarryOut`/`tileShareOut` are the outputs of the last cell.
- R8: In arithmetic mode, mask bits [63:32] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pinA | input | CELLS | Input A of each cell (index bit 0) |
| pinB | input | CELLS | Input B of each cell (index bit 1) |
| pinC | input | CELLS | Input C of each cell (index bit 2) |
| pinD | input | CELLS | Input D of each cell (index bit 3; first D in arithmetic mode) |
| pinE | input | CELLS | Input E of each cell (index bit 4; second D in arithmetic mode) |
| pinF | input | CELLS | Input F of each cell (index bit 5) |
| cfgMask | input | CELLS*64 | Truth-table mask, 64 bits per cell |
| cfgInCount | input | CELLS*3 | Used-input count per cell, lookup mode |
| cfgArith | input | CELLS | 1 selects arithmetic mode per cell |
| chainCarryIn | input | 1 | Carry into cell 0 |
| chainShareIn | input | 1 | Share into cell 0 |
| combOut | output | CELLS | Combinational result per cell |
| tileCarryOut | output | 1 | Carry out of the last cell |
| tileShareOut | output | 1 | Share out of the last cell |

## Verification
The bench builds the tile with CELLS=2. With only two cells, every pin pattern of a lookup cell can be swept for each count value from 0 to 7. It can also sweep every five-pin pattern of an arithmetic cell against all four carry/share input pairs. Two cells are the smallest chain that covers every boundary: arithmetic feeding arithmetic, arithmetic feeding lookup, and lookup feeding arithmetic. The expected sums and carries are computed from the mask arithmetic alone.

// File: rtl/lutc_pkg.sv
package lutc_pkg;
  localparam int LUT_INPUTS = 6;
  localparam int MASK_BITS  = 1 << LUT_INPUTS;
  localparam int CNT_BITS   = $clog2(LUT_INPUTS + 1);
  localparam int ARITH_SEL  = 4;
  localparam int ARITH_BITS = 1 << ARITH_SEL;

  typedef struct packed {
    logic                  arith;
    logic [LUT_INPUTS-1:0] inEnable;
  } cellStrobe_t;
endpackage

// File: rtl/lutc_lutmux.sv
module lutc_lutmux #(
  parameter int SEL_BITS = 6
) (
  input  logic [(1<<SEL_BITS)-1:0] table_i,
  input  logic [SEL_BITS-1:0]      sel,
  output logic                     bitOut
);
  localparam int LEAVES = 1 << SEL_BITS;

  // Heap-ordered tree: node 1 is the root, leaves sit at LEAVES..2*LEAVES-1.
  logic [2*LEAVES-1:1] node;

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    assign node[LEAVES + j] = table_i[j];
  end

  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    localparam int DEPTH = $clog2(i + 1) - 1;
    assign node[i] = sel[SEL_BITS-1-DEPTH] ? node[2*i+1] : node[2*i];
  end

  assign bitOut = node[1];
endmodule

// File: rtl/lutc_ctrl.sv
module lutc_ctrl
  import lutc_pkg::*;
#(
  parameter int CELLS = 20
) (
  input  logic [CELLS*CNT_BITS-1:0] cfgInCount,
  input  logic [CELLS-1:0]          cfgArith,
  output cellStrobe_t [CELLS-1:0]   strobes
);
  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [CNT_BITS-1:0] rawCount;
    logic [CNT_BITS-1:0] effCount;

    assign rawCount = cfgInCount[c*CNT_BITS +: CNT_BITS];

    always_comb begin
      if (rawCount > CNT_BITS'(LUT_INPUTS)) effCount = CNT_BITS'(LUT_INPUTS);
      else                                  effCount = rawCount;
    end

    for (genvar b = 0; b < LUT_INPUTS; b++) begin : g_en
      assign strobes[c].inEnable[b] = (effCount > CNT_BITS'(b));
    end

    assign strobes[c].arith = cfgArith[c];
  end
endmodule

// File: rtl/lutc_datapath.sv
module lutc_datapath
  import lutc_pkg::*;
#(
  parameter int CELLS = 20
) (
  input  logic [CELLS-1:0]           pinA,
  input  logic [CELLS-1:0]           pinB,
  input  logic [CELLS-1:0]           pinC,
  input  logic [CELLS-1:0]           pinD,
  input  logic [CELLS-1:0]           pinE,
  input  logic [CELLS-1:0]           pinF,
  input  logic [CELLS*MASK_BITS-1:0] cfgMask,
  input  cellStrobe_t [CELLS-1:0]    strobes,
  input  logic                       chainCarryIn,
  input  logic                       chainShareIn,
  output logic [CELLS-1:0]           combOut,
  output logic                       tileCarryOut,
  output logic                       tileShareOut
);
  logic [CELLS:0] carryRip;
  logic [CELLS:0] shareRip;

  assign carryRip[0]  = chainCarryIn;
  assign shareRip[0]  = chainShareIn;
  assign tileCarryOut = carryRip[CELLS];
  assign tileShareOut = shareRip[CELLS];

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    logic [MASK_BITS-1:0]  cellMask;
    logic [LUT_INPUTS-1:0] cellPins;
    logic [LUT_INPUTS-1:0] lutIdx;
    logic [ARITH_SEL-1:0]  propIdx;
    logic [ARITH_SEL-1:0]  genIdx;
    logic                  lutBit;
    logic                  propBit;
    logic                  genBit;

    assign cellMask = cfgMask[c*MASK_BITS +: MASK_BITS];
    assign cellPins = {pinF[c], pinE[c], pinD[c], pinC[c], pinB[c], pinA[c]};
    assign lutIdx   = cellPins & strobes[c].inEnable;
    assign propIdx  = {pinD[c], pinC[c], pinB[c], pinA[c]};
    assign genIdx   = {pinE[c], pinC[c], pinB[c], pinA[c]};

    lutc_lutmux #(.SEL_BITS(LUT_INPUTS)) u_lut (
      .table_i(cellMask),
      .sel    (lutIdx),
      .bitOut (lutBit)
    );

    lutc_lutmux #(.SEL_BITS(ARITH_SEL)) u_prop (
      .table_i(cellMask[ARITH_BITS-1:0]),
      .sel    (propIdx),
      .bitOut (propBit)
    );

    lutc_lutmux #(.SEL_BITS(ARITH_SEL)) u_gen (
      .table_i(cellMask[2*ARITH_BITS-1:ARITH_BITS]),
      .sel    (genIdx),
      .bitOut (genBit)
    );

    always_comb begin
      if (strobes[c].arith) begin
        combOut[c]    = propBit ^ carryRip[c] ^ shareRip[c];
        carryRip[c+1] = genBit | (propBit & carryRip[c]);
        shareRip[c+1] = genBit;
      end else begin
        combOut[c]    = lutBit;
        carryRip[c+1] = carryRip[c];
        shareRip[c+1] = shareRip[c];
      end
    end
  end
endmodule

// File: rtl/lutc_tile.sv
module lutc_tile
  import lutc_pkg::*;
#(
  parameter int CELLS = 20
) (
  input  logic [CELLS-1:0]           pinA,
  input  logic [CELLS-1:0]           pinB,
  input  logic [CELLS-1:0]           pinC,
  input  logic [CELLS-1:0]           pinD,
  input  logic [CELLS-1:0]           pinE,
  input  logic [CELLS-1:0]           pinF,
  input  logic [CELLS*MASK_BITS-1:0] cfgMask,
  input  logic [CELLS*CNT_BITS-1:0]  cfgInCount,
  input  logic [CELLS-1:0]           cfgArith,
  input  logic                       chainCarryIn,
  input  logic                       chainShareIn,
  output logic [CELLS-1:0]           combOut,
  output logic                       tileCarryOut,
  output logic                       tileShareOut
);
  cellStrobe_t [CELLS-1:0] strobes;

  lutc_ctrl #(.CELLS(CELLS)) u_ctrl (
    .cfgInCount(cfgInCount),
    .cfgArith  (cfgArith),
    .strobes   (strobes)
  );

  lutc_datapath #(.CELLS(CELLS)) u_dp (
    .pinA        (pinA),
    .pinB        (pinB),
    .pinC        (pinC),
    .pinD        (pinD),
    .pinE        (pinE),
    .pinF        (pinF),
    .cfgMask     (cfgMask),
    .strobes     (strobes),
    .chainCarryIn(chainCarryIn),
    .chainShareIn(chainShareIn),
    .combOut     (combOut),
    .tileCarryOut(tileCarryOut),
    .tileShareOut(tileShareOut)
  );
endmodule

// File: rtl/lutc_tile_chk.sv
module lutc_tile_chk
  import lutc_pkg::*;
#(
  parameter int CELLS = 20
) (
  input logic [CELLS-1:0]           pinA,
  input logic [CELLS*MASK_BITS-1:0] cfgMask,
  input logic [CELLS*CNT_BITS-1:0]  cfgInCount,
  input logic [CELLS-1:0]           cfgArith,
  input logic                       chainCarryIn,
  input logic                       chainShareIn,
  input logic [CELLS-1:0]           combOut,
  input logic                       tileCarryOut,
  input logic                       tileShareOut
);
  always_comb begin
    if (cfgArith == '0) begin
      assert_carry_pass_R6: assert (tileCarryOut == chainCarryIn)
        else $error("carry not passed through lookup-only chain");
      assert_share_pass_R7: assert (tileShareOut == chainShareIn)
        else $error("share not passed through lookup-only chain");
    end
    for (int c = 0; c < CELLS; c++) begin
      if (!cfgArith[c] && cfgInCount[c*CNT_BITS +: CNT_BITS] == CNT_BITS'(0)) begin
        assert_const_out_R3: assert (combOut[c] == cfgMask[c*MASK_BITS])
          else $error("zero-input cell not constant");
      end
      if (!cfgArith[c] && cfgInCount[c*CNT_BITS +: CNT_BITS] == CNT_BITS'(1)) begin
        assert_one_input_R1: assert (combOut[c] == cfgMask[c*MASK_BITS + int'(pinA[c])])
          else $error("one-input cell selects wrong mask bit");
      end
    end
  end
endmodule

bind lutc_tile lutc_tile_chk #(.CELLS(CELLS)) u_chk (
  .pinA        (pinA),
  .cfgMask     (cfgMask),
  .cfgInCount  (cfgInCount),
  .cfgArith    (cfgArith),
  .chainCarryIn(chainCarryIn),
  .chainShareIn(chainShareIn),
  .combOut     (combOut),
  .tileCarryOut(tileCarryOut),
  .tileShareOut(tileShareOut)
);

// File: tb/lutc_tile_tb.sv
module lutc_tile_tb;
  localparam int CELLS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [CELLS-1:0]    pinA, pinB, pinC, pinD, pinE, pinF;
  logic [CELLS*64-1:0] cfgMask;
  logic [CELLS*3-1:0]  cfgInCount;
  logic [CELLS-1:0]    cfgArith;
  logic                chainCarryIn, chainShareIn;
  logic [CELLS-1:0]    combOut;
  logic                tileCarryOut, tileShareOut;

  int checks = 0;
  int errors = 0;
  logic [63:0] lfsr = 64'hACE1_2468_9BDF_1357;

  lutc_tile #(.CELLS(CELLS)) u_dut (
    .pinA(pinA), .pinB(pinB), .pinC(pinC), .pinD(pinD), .pinE(pinE), .pinF(pinF),
    .cfgMask(cfgMask), .cfgInCount(cfgInCount), .cfgArith(cfgArith),
    .chainCarryIn(chainCarryIn), .chainShareIn(chainShareIn),
    .combOut(combOut), .tileCarryOut(tileCarryOut), .tileShareOut(tileShareOut)
  );

  function automatic logic [63:0] nextRand(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  function automatic logic normEval(input logic [63:0] m, input logic [5:0] p, input int cnt);
    int eff = (cnt > 6) ? 6 : cnt;
    logic [5:0] keep = 6'((1 << eff) - 1);
    return m[p & keep];
  endfunction

  // returns {sum, carryOut, shareOut}
  function automatic logic [2:0] arithEval(input logic [63:0] m, input logic [5:0] p,
                                           input logic cin, input logic sin);
    logic pr = m[{p[3], p[2], p[1], p[0]}];
    logic gn = m[16 + int'({p[4], p[2], p[1], p[0]})];
    return {pr ^ cin ^ sin, gn | (pr & cin), gn};
  endfunction

  task automatic setPins(input int c, input logic [5:0] v);
    pinA[c] = v[0]; pinB[c] = v[1]; pinC[c] = v[2];
    pinD[c] = v[3]; pinE[c] = v[4]; pinF[c] = v[5];
  endtask

  task automatic check(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pinA = '0; pinB = '0; pinC = '0; pinD = '0; pinE = '0; pinF = '0;
    cfgMask = '0; cfgInCount = '0; cfgArith = '0;
    chainCarryIn = 1'b1; chainShareIn = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    settle();
    // Initial state: all-zero config, lookup mode, pass-through chain (R6, R3)
    check(combOut[0], 1'b0, "R3 initial const");
    check(tileCarryOut, 1'b1, "R6 initial carry pass");
    check(tileShareOut, 1'b0, "R6 initial share pass");

    // Lookup sweep across every count and every pin pattern (R1, R2, R6, R7)
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 3; k++) begin
        logic [63:0] m0, m1;
        lfsr = nextRand(lfsr); m0 = lfsr;
        lfsr = nextRand(lfsr); m1 = lfsr;
        for (int p = 0; p < 64; p++) begin
          @(posedge clk);
          cfgArith = 2'b00;
          cfgMask = {m1, m0};
          cfgInCount = {3'd6, 3'(n)};
          setPins(0, 6'(p));
          setPins(1, ~6'(p));
          chainCarryIn = p[0];
          chainShareIn = p[1];
          settle();
          check(combOut[0], normEval(m0, 6'(p), n), (n > 6) ? "R2 count clamp" : "R1 lookup index");
          check(combOut[1], normEval(m1, ~6'(p), 6), "R1 six-input lookup");
          check(tileCarryOut, p[0], "R6 carry pass");
          check(tileShareOut, p[1], "R7 share pass");
        end
      end
    end

    // Inverter and constants (R3)
    for (int p = 0; p < 64; p++) begin
      @(posedge clk);
      cfgArith = 2'b00;
      cfgInCount = {3'd0, 3'd1};
      cfgMask = {64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFF9};
      setPins(0, 6'(p));
      setPins(1, 6'(p));
      settle();
      check(combOut[0], ~p[0], "R3 inverter");
      check(combOut[1], 1'b0, "R3 constant zero");
    end

    // Arithmetic chains in three mode combinations (R4, R5, R7, R8)
    for (int mode = 0; mode < 3; mode++) begin
      for (int k = 0; k < 4; k++) begin
        logic [63:0] m0, m1;
        lfsr = nextRand(lfsr); m0 = lfsr;
        lfsr = nextRand(lfsr); m1 = lfsr;
        for (int p = 0; p < 32; p++) begin
          for (int cs = 0; cs < 4; cs++) begin
            logic [5:0] p1;
            logic [2:0] r0, r1;
            logic c1, s1, expC, expS, exp0, exp1;
            lfsr = nextRand(lfsr);
            p1 = lfsr[5:0];
            @(posedge clk);
            cfgArith = (mode == 0) ? 2'b11 : (mode == 1) ? 2'b01 : 2'b10;
            cfgInCount = {3'd6, 3'd6};
            cfgMask = {m1, m0};
            setPins(0, {lfsr[8], 5'(p)});
            setPins(1, p1);
            chainCarryIn = cs[0];
            chainShareIn = cs[1];
            settle();
            if (mode == 2) begin
              exp0 = normEval(m0, {lfsr[8], 5'(p)}, 6);
              c1 = cs[0]; s1 = cs[1];
            end else begin
              r0 = arithEval(m0, {1'b0, 5'(p)}, cs[0], cs[1]);
              exp0 = r0[2]; c1 = r0[1]; s1 = r0[0];
            end
            if (mode == 1) begin
              exp1 = normEval(m1, p1, 6);
              expC = c1; expS = s1;
            end else begin
              r1 = arithEval(m1, p1, c1, s1);
              exp1 = r1[2]; expC = r1[1]; expS = r1[0];
            end
            // upper mask halves are random, so R8 is exercised on every arithmetic check
            check(combOut[0], exp0, (mode == 2) ? "R6 lookup beside arith" : "R4 sum R8");
            check(combOut[1], exp1, (mode == 1) ? "R6 lookup after arith" : "R4 chained sum");
            check(tileCarryOut, expC, "R5 R7 carry out");
            check(tileShareOut, expS, "R5 R7 share out");
          end
        end
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule